// File: doc/BRIEF.md
# Accumulator Round and Store Stage

This block sits between a wide multiply-accumulate register and the memory write path of a fixed-point datapath. It holds a 40-bit two's complement accumulator and, on request, turns it into a 16-bit word for storing. The word comes from bits 31:16 of the accumulator after three optional steps, in this order: a signed shift, a round to nearest, and a clamp to the 16-bit range. The clamp acts only on the outgoing word. The accumulator itself is never touched by a store.

Rounding adds half of the dropped 16-bit field and then discards that field. A mode input picks plain half-up rounding or round-half-to-even, which avoids the upward drift of the plain mode. The clamp is enabled by its own mode bit. A second mode bit chooses signed limits (7FFFh / 8000h) or unsigned limits (FFFFh / 0000h). A separate command rounds the accumulator in place in one clock. It can optionally clamp the result to the 32-bit signed range held in the 40-bit register.

Top module: `acc_store_stage`

## Requirements
- R1: While reset is low, and at its release, acc_q, st_valid and st_data are all zero.
- R2: st_valid is high in exactly the cycle after a cycle with st_req high. st_data then holds bits 31:16 of the value after shift, rounding and clamping, computed from the acc_q of the request cycle.
- R3: st_shift is a 5-bit two's complement amount (-16..+15) applied to the sign-extended accumulator before rounding and clamping. Positive values shift left; negative values shift right arithmetically, and the bits shifted out are lost.
- R4: With rnd_on=1 and rnd_even=0, the store path adds 0x8000 to the shifted value and then takes bits 31:16, so a low field of 0x8000 or above rounds up.
- R5: With rnd_on=1 and rnd_even=1, no increment is made when the low 16 bits equal exactly 0x8000 and bit 16 is 0. In every other case the result is as in R4.
- R6: With sat_store=1 and sign_ext=1, a value above 0x7FFF_FFFF stores 7FFFh and a value below -2^31 stores 8000h. With sat_store=0, bits 31:16 are stored unclamped even if they wrap. Overflow includes significant bits lost by a left shift and a carry caused by rounding.
- R7: With sat_store=1 and sign_ext=0, a negative value (sign bit set) stores 0000h and a value above 0xFFFF_FFFF stores FFFFh.
- R8: A store never changes acc_q.
- R9: rnd_cmd=1 loads acc_q, one cycle later, with the accumulator rounded as in R4/R5 (as selected by rnd_even) and its low 16 bits cleared. Without sat_acc, a carry out of bit 39 wraps. A store in the same cycle uses the value before rounding. ld_en has priority over rnd_cmd.
- R10: With sat_acc=1, an in-place round whose result leaves the 32-bit signed range loads 00_7FFF_FFFFh (above the range) or FF_8000_0000h (below the range).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Load ld_val into the accumulator |
| ld_val | input | 40 | Value to load |
| st_req | input | 1 | Produce a store word from the current accumulator |
| st_shift | input | 5 | Signed shift amount for the store path |
| rnd_on | input | 1 | Enable rounding on the store path |
| rnd_even | input | 1 | 1: round half to even; 0: round half up (store path and in-place round) |
| sat_store | input | 1 | Clamp the store word to 16 bits |
| sign_ext | input | 1 | 1: signed clamp limits; 0: unsigned clamp limits |
| rnd_cmd | input | 1 | Round the accumulator in place |
| sat_acc | input | 1 | Clamp the in-place round result to the 32-bit signed range |
| acc_q | output | 40 | Accumulator contents |
| st_valid | output | 1 | Store word valid |
| st_data | output | 16 | Store word |

## Verification
The store path is driven with low fields just below, exactly at and just above the half point, with both parities of bit 16. This separates half-up rounding from half-to-even. Shift amounts at both extremes (+15, -16) and negative operands shifted right check that sign fill and shift direction are correct. The clamp is tried with values just past each signed limit, with left-shift overflow and with a rounding carry. Each of these is run with the clamp enabled and disabled, and in the unsigned mode. These cases tell a wrapped result from a clamped one and the signed limits from the unsigned ones. In-place rounds are tried with and without the accumulator clamp, together with a store in the same cycle and with a competing load, to show which value each operation sees.

// File: rtl/acc_store_pkg.sv
package acc_store_pkg;
   typedef enum logic [1:0] {
      SAT_NONE = 2'd0,
      SAT_HI   = 2'd1,
      SAT_LO   = 2'd2
   } sat_kind_e;
endpackage

// File: rtl/acc_shift.sv
module acc_shift #(
   parameter int IN_W  = 40,
   parameter int OUT_W = 56,
   parameter int SH_W  = 5
) (
   input  logic [IN_W-1:0]         din,
   input  logic [SH_W-1:0]         sh,
   output logic signed [OUT_W-1:0] dout
);
   localparam int PAD_W = OUT_W - IN_W;

   if (PAD_W < 1) begin : g_bad_width
      $error("acc_shift: OUT_W must exceed IN_W");
   end

   logic signed [OUT_W-1:0] ext;
   logic [SH_W-1:0]         mag;

   always_comb begin
      ext = {{PAD_W{din[IN_W-1]}}, din};
      mag = sh[SH_W-1] ? (~sh + 1'b1) : sh;
      if (sh[SH_W-1]) dout = ext >>> mag;
      else            dout = ext <<< mag;
   end
endmodule

// File: rtl/acc_round.sv
module acc_round #(
   parameter int W      = 56,
   parameter int FRAC_W = 16
) (
   input  logic [W-1:0]        v,
   input  logic                en,
   input  logic                even,
   output logic [W-FRAC_W-1:0] r_hi
);
   localparam int HI_W = W - FRAC_W;
   localparam logic [W-1:0] HALF = W'(1) << (FRAC_W - 1);

   if (FRAC_W < 1 || HI_W < 1) begin : g_bad_width
      $error("acc_round: FRAC_W must lie inside W");
   end

   logic         tie, skip;
   logic [W-1:0] sum;

   always_comb begin
      tie  = (v[FRAC_W-1:0] == HALF[FRAC_W-1:0]);
      skip = even && tie && !v[FRAC_W];
      sum  = v + ((en && !skip) ? HALF : '0);
      r_hi = sum[W-1:FRAC_W];
   end
endmodule

// File: rtl/acc_clamp.sv
module acc_clamp
   import acc_store_pkg::*;
#(
   parameter int G_W = 25
) (
   input  logic [G_W-1:0] guard,
   input  logic           signed_mode,
   output sat_kind_e      kind
);
   if (G_W < 3) begin : g_bad_width
      $error("acc_clamp: at least three guard bits are needed");
   end

   logic all_same, upper_set;

   always_comb begin
      all_same  = (&guard) | ~(|guard);
      upper_set = |guard[G_W-2:1];
      kind      = SAT_NONE;
      if (signed_mode) begin
         if (!all_same) kind = guard[G_W-1] ? SAT_LO : SAT_HI;
      end else begin
         if (guard[G_W-1])   kind = SAT_LO;
         else if (upper_set) kind = SAT_HI;
      end
   end
endmodule

// File: rtl/acc_store_stage.sv
module acc_store_stage
   import acc_store_pkg::*;
#(
   parameter int ACC_W  = 40,
   parameter int WORD_W = 16,
   parameter int SH_W   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic [ACC_W-1:0]  ld_val,
   input  logic              st_req,
   input  logic [SH_W-1:0]   st_shift,
   input  logic              rnd_on,
   input  logic              rnd_even,
   input  logic              sat_store,
   input  logic              sign_ext,
   input  logic              rnd_cmd,
   input  logic              sat_acc,
   output logic [ACC_W-1:0]  acc_q,
   output logic              st_valid,
   output logic [WORD_W-1:0] st_data
);
   localparam int PROD_W  = 2 * WORD_W;
   localparam int MAX_LSH = (1 << (SH_W - 1)) - 1;
   localparam int EXT_W   = ACC_W + MAX_LSH + 1;
   localparam int SHI_W   = EXT_W - WORD_W;
   localparam int SG_W    = EXT_W - PROD_W + 1;
   localparam int RW      = ACC_W + 1;
   localparam int RHI_W   = RW - WORD_W;
   localparam int AG_W    = RW - PROD_W + 1;
   localparam int TOP_W   = ACC_W - PROD_W + 1;

   if (ACC_W <= PROD_W) begin : g_bad_acc
      $error("acc_store_stage: ACC_W must exceed twice WORD_W");
   end
   if (SH_W < 2) begin : g_bad_sh
      $error("acc_store_stage: SH_W must be at least 2");
   end

   // store path: shift, round, clamp
   logic signed [EXT_W-1:0] shifted;
   logic [SHI_W-1:0]        st_hi;
   sat_kind_e               st_kind;
   logic [WORD_W-1:0]       st_word;

   acc_shift #(.IN_W(ACC_W), .OUT_W(EXT_W), .SH_W(SH_W)) shift_i (
      .din (acc_q),
      .sh  (st_shift),
      .dout(shifted)
   );

   acc_round #(.W(EXT_W), .FRAC_W(WORD_W)) st_round_i (
      .v   (shifted),
      .en  (rnd_on),
      .even(rnd_even),
      .r_hi(st_hi)
   );

   acc_clamp #(.G_W(SG_W)) st_clamp_i (
      .guard      (st_hi[SHI_W-1:WORD_W-1]),
      .signed_mode(sign_ext),
      .kind       (st_kind)
   );

   always_comb begin
      st_word = st_hi[WORD_W-1:0];
      if (sat_store) begin
         unique case (st_kind)
            SAT_HI:  st_word = sign_ext ? {1'b0, {(WORD_W-1){1'b1}}} : '1;
            SAT_LO:  st_word = sign_ext ? {1'b1, {(WORD_W-1){1'b0}}} : '0;
            default: st_word = st_hi[WORD_W-1:0];
         endcase
      end
   end

   // in-place round path
   logic [RHI_W-1:0] acc_hi;
   sat_kind_e        acc_kind;
   logic [ACC_W-1:0] acc_rnd;

   acc_round #(.W(RW), .FRAC_W(WORD_W)) acc_round_i (
      .v   ({acc_q[ACC_W-1], acc_q}),
      .en  (1'b1),
      .even(rnd_even),
      .r_hi(acc_hi)
   );

   acc_clamp #(.G_W(AG_W)) acc_clamp_i (
      .guard      (acc_hi[RHI_W-1:WORD_W-1]),
      .signed_mode(1'b1),
      .kind       (acc_kind)
   );

   always_comb begin
      acc_rnd = {acc_hi[RHI_W-2:0], {WORD_W{1'b0}}};
      if (sat_acc) begin
         unique case (acc_kind)
            SAT_HI:  acc_rnd = {{TOP_W{1'b0}}, {(PROD_W-1){1'b1}}};
            SAT_LO:  acc_rnd = {{TOP_W{1'b1}}, {(PROD_W-1){1'b0}}};
            default: acc_rnd = {acc_hi[RHI_W-2:0], {WORD_W{1'b0}}};
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q    <= '0;
         st_valid <= 1'b0;
         st_data  <= '0;
      end else begin
         if (ld_en)        acc_q <= ld_val;
         else if (rnd_cmd) acc_q <= acc_rnd;
         st_valid <= st_req;
         if (st_req) st_data <= st_word;
      end
   end
endmodule

// File: rtl/acc_store_chk.sv
module acc_store_chk #(
   parameter int ACC_W  = 40,
   parameter int WORD_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ld_en,
   input logic              st_req,
   input logic              sat_store,
   input logic              sign_ext,
   input logic              rnd_cmd,
   input logic              sat_acc,
   input logic [ACC_W-1:0]  acc_q,
   input logic              st_valid,
   input logic [WORD_W-1:0] st_data
);
   localparam int PROD_W = 2 * WORD_W;

   // R2
   st_valid_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_req |=> st_valid);

   // R2
   st_valid_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !st_req |=> !st_valid);

   // R8
   acc_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_en && !rnd_cmd) |=> $stable(acc_q));

   // R7
   unsigned_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_req && sat_store && !sign_ext && acc_q[ACC_W-1]) |=> (st_data == '0));

   // R9
   rnd_low_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rnd_cmd && !ld_en && !sat_acc) |=> (acc_q[WORD_W-1:0] == '0));

   // R10
   acc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rnd_cmd && !ld_en && sat_acc) |=>
         ((&acc_q[ACC_W-1:PROD_W-1]) || !(|acc_q[ACC_W-1:PROD_W-1])));
endmodule

bind acc_store_stage acc_store_chk #(.ACC_W(ACC_W), .WORD_W(WORD_W)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .ld_en    (ld_en),
   .st_req   (st_req),
   .sat_store(sat_store),
   .sign_ext (sign_ext),
   .rnd_cmd  (rnd_cmd),
   .sat_acc  (sat_acc),
   .acc_q    (acc_q),
   .st_valid (st_valid),
   .st_data  (st_data)
);

// File: tb/acc_store_stage_tb_top.sv
`timescale 1ns/1ps
module acc_store_stage_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        ld_en, st_req, rnd_on, rnd_even, sat_store, sign_ext, rnd_cmd, sat_acc;
   logic [39:0] ld_val;
   logic [4:0]  st_shift;
   logic [39:0] acc_q;
   logic        st_valid;
   logic [15:0] st_data;

   int n_chk  = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   acc_store_stage dut_i (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_val(ld_val),
      .st_req(st_req), .st_shift(st_shift), .rnd_on(rnd_on), .rnd_even(rnd_even),
      .sat_store(sat_store), .sign_ext(sign_ext), .rnd_cmd(rnd_cmd), .sat_acc(sat_acc),
      .acc_q(acc_q), .st_valid(st_valid), .st_data(st_data)
   );

   // fields: acc[68:29] shift[28:24] rnd[23] even[22] sat[21] sxm[20] expected[19:4] req[3:0]
   localparam int NV = 20;
   localparam logic [68:0] VEC [NV] = '{
      {40'h00_1234_5678, 5'h00, 4'b0001, 16'h1234, 4'd2},  // R2 plain pick
      {40'h00_1234_8000, 5'h00, 4'b1001, 16'h1235, 4'd4},  // R4 tie rounds up
      {40'h00_1234_8000, 5'h00, 4'b1101, 16'h1234, 4'd5},  // R5 tie, even kept
      {40'h00_1235_8000, 5'h00, 4'b1101, 16'h1236, 4'd5},  // R5 tie, odd goes up
      {40'h00_1234_7FFF, 5'h00, 4'b1001, 16'h1234, 4'd4},  // R4 below half
      {40'h00_1234_8001, 5'h00, 4'b1101, 16'h1235, 4'd5},  // R5 above half
      {40'h00_0000_1234, 5'h08, 4'b0001, 16'h0012, 4'd3},  // R3 left 8
      {40'h00_1234_5678, 5'h1C, 4'b0001, 16'h0123, 4'd3},  // R3 right 4
      {40'hFF_F000_0000, 5'h1C, 4'b0001, 16'hFF00, 4'd3},  // R3 sign fill
      {40'h12_3456_7890, 5'h10, 4'b0001, 16'h0012, 4'd3},  // R3 right 16
      {40'h00_8000_0000, 5'h00, 4'b0011, 16'h7FFF, 4'd6},  // R6 positive clamp
      {40'h00_8000_0000, 5'h00, 4'b0001, 16'h8000, 4'd6},  // R6 wrap without clamp
      {40'hFF_7FFF_FFFF, 5'h00, 4'b0011, 16'h8000, 4'd6},  // R6 negative clamp
      {40'h00_0001_0000, 5'h0F, 4'b0011, 16'h7FFF, 4'd6},  // R6 left-shift overflow
      {40'h00_0001_0000, 5'h0F, 4'b0001, 16'h8000, 4'd6},  // R6 same, wraps
      {40'h00_8000_0000, 5'h00, 4'b0010, 16'h8000, 4'd7},  // R7 unsigned in range
      {40'hFF_FFFF_0000, 5'h00, 4'b0010, 16'h0000, 4'd7},  // R7 negative to zero
      {40'h01_0000_0000, 5'h00, 4'b0010, 16'hFFFF, 4'd7},  // R7 unsigned top
      {40'h00_7FFF_8000, 5'h00, 4'b1011, 16'h7FFF, 4'd6},  // R6 rounding carry clamps
      {40'h00_0012_3480, 5'h08, 4'b1101, 16'h1234, 4'd5}   // R5 shift then even tie
   };

   task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle_inputs();
      ld_en = 0; ld_val = '0; st_req = 0; st_shift = '0; rnd_on = 0; rnd_even = 0;
      sat_store = 0; sign_ext = 1; rnd_cmd = 0; sat_acc = 0;
   endtask

   task automatic load_acc(input logic [39:0] v);
      @(negedge clk);
      ld_en = 1; ld_val = v;
      @(negedge clk);
      ld_en = 0;
   endtask

   task automatic do_round(input string tag, input logic [39:0] v, input logic even,
                           input logic sat, input logic [39:0] exp);
      load_acc(v);
      rnd_cmd = 1; rnd_even = even; sat_acc = sat;
      @(negedge clk);
      rnd_cmd = 0; sat_acc = 0; rnd_even = 0;
      check(tag, acc_q, exp);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      idle_inputs();
      rst_n = 0;
      repeat (3) @(negedge clk);
      check("R1 acc_q in reset", acc_q, 40'h0);
      check("R1 st_valid in reset", {39'h0, st_valid}, 40'h0);
      check("R1 st_data in reset", {24'h0, st_data}, 40'h0);
      rst_n = 1;

      for (int i = 0; i < NV; i++) begin
         load_acc(VEC[i][68:29]);
         st_req = 1; st_shift = VEC[i][28:24];
         rnd_on = VEC[i][23]; rnd_even = VEC[i][22];
         sat_store = VEC[i][21]; sign_ext = VEC[i][20];
         @(negedge clk);
         st_req = 0;
         check($sformatf("R%0d vector %0d st_data", VEC[i][3:0], i),
               {24'h0, st_data}, {24'h0, VEC[i][19:4]});
         check($sformatf("R2 vector %0d st_valid", i), {39'h0, st_valid}, 40'h1);
         check($sformatf("R8 vector %0d acc kept", i), acc_q, VEC[i][68:29]);
         @(negedge clk);
         check($sformatf("R2 vector %0d st_valid drop", i), {39'h0, st_valid}, 40'h0);
         idle_inputs();
      end

      do_round("R9 round half up", 40'h00_1234_8000, 1'b0, 1'b0, 40'h00_1235_0000);
      do_round("R9 round half even", 40'h00_1234_8000, 1'b1, 1'b0, 40'h00_1234_0000);
      do_round("R9 no clamp carry", 40'h00_7FFF_C000, 1'b0, 1'b0, 40'h00_8000_0000);
      do_round("R10 clamp high", 40'h00_7FFF_C000, 1'b0, 1'b1, 40'h00_7FFF_FFFF);
      do_round("R10 clamp low", 40'hFF_0000_0000, 1'b0, 1'b1, 40'hFF_8000_0000);

      // R9: store and in-place round in the same cycle
      load_acc(40'h00_1234_8000);
      st_req = 1; rnd_cmd = 1;
      @(negedge clk);
      st_req = 0; rnd_cmd = 0;
      check("R9 store sees pre-round value", {24'h0, st_data}, 40'h1234);
      check("R9 acc rounded alongside store", acc_q, 40'h00_1235_0000);

      // R9: load wins over round
      @(negedge clk);
      ld_en = 1; ld_val = 40'h00_0000_00AB; rnd_cmd = 1;
      @(negedge clk);
      ld_en = 0; rnd_cmd = 0;
      check("R9 load priority", acc_q, 40'h00_0000_00AB);

      // R1: reset clears again after activity
      rst_n = 0;
      @(negedge clk);
      check("R1 acc_q after second reset", acc_q, 40'h0);
      rst_n = 1;
      @(negedge clk);
      finish_run();
   end
endmodule